// File: doc/BRIEF.md
# Glitch-Free Audio Clock Family Switch

This block chooses which of two audio clock families reaches a pair of audio clock outputs. One family is derived from a 44.1 kHz sample rate and the other from 48 kHz. Each family supplies two source clocks, one at 384 times the sample rate and one at 768 times. A sample-rate select pin picks the family. A chip-enable pin either runs the block or parks it. All sequencing runs in a reference clock domain, which is nominally 36.864 MHz (768 × 48 kHz).

When the select pin changes, the controller first turns off the clock family in use. It then holds both audio outputs low for a fixed quiet window and only after that enables the newly selected family. Each source clock is gated by an enable that is resynchronised into that clock's own domain on its falling edge. The gate therefore opens and closes only while that clock is low, so no shortened high pulse can appear. When chip enable drops, the outputs fall low and the controller goes idle. When chip enable rises again, the outputs stay low until a lock wait has elapsed. A valid flag tells downstream logic when the audio clocks can be trusted.

Top module: `aclk_switch`

## Requirements
- R1: While reset is asserted and afterwards while chip enable is low, both audio outputs and the valid flag are low.
- R2: With valid high and after a few source periods of settling, audio output 1 equals the 384fs source of the selected family and audio output 2 equals the 768fs source. Select low (0) picks the 44.1 kHz family and select high (1) picks the 48 kHz family.
- R3: After chip enable rises, valid stays low for LOCK_CYC + 2 reference edges and is high after edge LOCK_CYC + 3. The first reference rising edge after the change counts as edge 1.
- R4: A change of the select pin during normal running leaves valid high through reference edge 2 and drops it at edge 3. Valid rises again at edge QUIET_CYC + 3.
- R5: Both audio outputs are low from 10 reference edges after a select change until valid returns.
- R6: A select change seen during a quiet window restarts that window. Valid then rises QUIET_CYC + 3 edges after the last change.
- R7: When chip enable falls, valid is low by reference edge 3 and both audio outputs are low by edge 15. Select changes while the chip is disabled leave the outputs low.
- R8: Every high pulse on an audio output lasts at least half the period of the source it came from, so no runt pulse appears on any switch or disable.
- R9: At no time are the enables of both families active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for sequencing (nominal 36.864 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, asynchronous; high runs, low parks |
| fs_sel | input | 1 | Sample-rate select, asynchronous; 0 = 44.1 kHz, 1 = 48 kHz |
| src44_x1 | input | 1 | 384fs source clock of the 44.1 kHz family |
| src44_x2 | input | 1 | 768fs source clock of the 44.1 kHz family |
| src48_x1 | input | 1 | 384fs source clock of the 48 kHz family |
| src48_x2 | input | 1 | 768fs source clock of the 48 kHz family |
| aud_out1 | output | 1 | Gated 384fs audio clock |
| aud_out2 | output | 1 | Gated 768fs audio clock |
| aud_valid | output | 1 | High when the audio clocks are running at the selected rate |

## Verification
The hazardous overlap is a select change that arrives in the same reference cycle in which a quiet window or the lock wait expires. The expiry would release a family while the restart must keep it gated. Random select toggles with gaps down to a single cycle are laid over directed back-to-back toggles and re-enables, so some changes land on the expiry cycle. Each run is judged by the outputs matching the expected source after settling, by valid timing counted in reference edges, and by a pulse-width monitor that records the narrowest high pulse on each output across the whole run.

// File: rtl/aclk_pkg.sv
`timescale 1ns/1ps
package aclk_pkg;
   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_LOCK  = 2'd1,
      ST_QUIET = 2'd2,
      ST_RUN   = 2'd3
   } ctl_state_t;

   function automatic int cmax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/aclk_sync.sv
`timescale 1ns/1ps
module aclk_sync #(
   parameter int STAGES   = 2,
   parameter bit NEG_EDGE = 1'b0,
   parameter bit RST_VAL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   if (STAGES < 2) begin : g_bad
      $error("aclk_sync: STAGES must be at least 2");
   end

   if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) ff <= {STAGES{RST_VAL}};
         else        ff <= {ff[STAGES-2:0], d};
      end
   end else begin : g_pos
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= {STAGES{RST_VAL}};
         else        ff <= {ff[STAGES-2:0], d};
      end
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/aclk_seq.sv
`timescale 1ns/1ps
module aclk_seq
   import aclk_pkg::*;
#(
   parameter int QUIET_CYC   = 32,
   parameter int LOCK_CYC    = 184320,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic chip_en,
   input  logic fs_sel,
   output logic en44_q,
   output logic en48_q,
   output logic valid_q
);
   localparam int MAXC = cmax(QUIET_CYC, LOCK_CYC);
   localparam int CW   = $clog2(MAXC + 1);

   logic       ce_s, sel_s, sel_d, chg;
   logic       fam, nfam;
   logic [CW-1:0] cnt, ncnt;
   ctl_state_t state, nxt;

   aclk_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0), .RST_VAL(1'b0)) u_ce_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(chip_en), .q(ce_s));
   aclk_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0), .RST_VAL(1'b0)) u_sel_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(fs_sel), .q(sel_s));

   assign chg = sel_s ^ sel_d;

   always_comb begin
      nxt  = state;
      ncnt = cnt;
      nfam = fam;
      if (!ce_s) begin
         nxt  = ST_OFF;
         ncnt = '0;
      end else begin
         case (state)
            ST_OFF: begin
               nxt  = ST_LOCK;
               ncnt = '0;
            end
            ST_LOCK: begin
               if (cnt == CW'(LOCK_CYC - 1)) begin
                  nxt  = ST_RUN;
                  nfam = sel_s;
                  ncnt = '0;
               end else begin
                  ncnt = cnt + CW'(1);
               end
            end
            ST_RUN: begin
               if (chg) begin
                  nxt  = ST_QUIET;
                  ncnt = '0;
               end
            end
            default: begin
               if (chg) begin
                  ncnt = '0;
               end else if (cnt == CW'(QUIET_CYC - 1)) begin
                  nxt  = ST_RUN;
                  nfam = sel_s;
                  ncnt = '0;
               end else begin
                  ncnt = cnt + CW'(1);
               end
            end
         endcase
      end
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_OFF;
         cnt     <= '0;
         fam     <= 1'b0;
         sel_d   <= 1'b0;
         en44_q  <= 1'b0;
         en48_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         state   <= nxt;
         cnt     <= ncnt;
         fam     <= nfam;
         sel_d   <= sel_s;
         en44_q  <= (nxt == ST_RUN) && !nfam;
         en48_q  <= (nxt == ST_RUN) && nfam;
         valid_q <= (nxt == ST_RUN);
      end
   end

   // R3
   win_end_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(valid_q) |-> ($past(cnt) == CW'(LOCK_CYC - 1) || $past(cnt) == CW'(QUIET_CYC - 1)));

   // R4
   quiet_entry_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (valid_q && chg && ce_s) |=> !valid_q);

   // R6
   restart_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (state == ST_QUIET && chg && ce_s) |=> (cnt == '0 && !valid_q));

   // R7
   ce_drop_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !ce_s |=> !valid_q);

   // R9
   fam_excl_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $onehot0({en44_q, en48_q}));
endmodule

// File: rtl/aclk_gate.sv
`timescale 1ns/1ps
module aclk_gate #(
   parameter int SYNC_STAGES = 2
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic en_req,
   output logic gclk
);
   logic en_s;

   aclk_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1), .RST_VAL(1'b0)) u_en_sync (
      .clk(src_clk), .rst_n(rst_n), .d(en_req), .q(en_s));

   assign gclk = src_clk & en_s;

   // R8
   always @(en_s) begin
      if (rst_n) begin
         glitchless_chk: assert (!src_clk)
            else $error("gate enable moved while source clock high");
      end
   end
endmodule

// File: rtl/aclk_switch.sv
`timescale 1ns/1ps
module aclk_switch #(
   parameter int QUIET_CYC   = 32,
   parameter int LOCK_CYC    = 184320,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic chip_en,
   input  logic fs_sel,
   input  logic src44_x1,
   input  logic src44_x2,
   input  logic src48_x1,
   input  logic src48_x2,
   output logic aud_out1,
   output logic aud_out2,
   output logic aud_valid
);
   localparam int NSRC = 4;

   if (QUIET_CYC < 2) begin : g_bad_q
      $error("aclk_switch: QUIET_CYC must be at least 2");
   end
   if (LOCK_CYC < 2) begin : g_bad_l
      $error("aclk_switch: LOCK_CYC must be at least 2");
   end

   logic en44, en48;
   logic [NSRC-1:0] src_v, en_v, g_v;

   aclk_seq #(.QUIET_CYC(QUIET_CYC), .LOCK_CYC(LOCK_CYC), .SYNC_STAGES(SYNC_STAGES)) u_seq (
      .ref_clk(ref_clk), .rst_n(rst_n), .chip_en(chip_en), .fs_sel(fs_sel),
      .en44_q(en44), .en48_q(en48), .valid_q(aud_valid));

   // index bit 1 = family (0: 44.1 kHz, 1: 48 kHz), bit 0 = multiple (0: 384fs, 1: 768fs)
   assign src_v = {src48_x2, src48_x1, src44_x2, src44_x1};
   assign en_v  = {en48, en48, en44, en44};

   for (genvar i = 0; i < NSRC; i++) begin : g_gate
      aclk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
         .src_clk(src_v[i]), .rst_n(rst_n), .en_req(en_v[i]), .gclk(g_v[i]));
   end

   assign aud_out1 = g_v[0] | g_v[2];
   assign aud_out2 = g_v[1] | g_v[3];
endmodule

// File: tb/aclk_switch_test.sv
`timescale 1ns/1ps
module aclk_switch_test;
   localparam int QC = 32;
   localparam int LC = 20;

   logic ref_clk = 1'b0, rst_n = 1'b0, chip_en = 1'b0, fs_sel = 1'b0;
   logic src44_x1 = 1'b0, src44_x2 = 1'b0, src48_x1 = 1'b0, src48_x2 = 1'b0;
   logic aud_out1, aud_out2, aud_valid;
   int ncmp = 0, nerr = 0;
   bit done = 1'b0;
   real r1 = 0.0, r2 = 0.0, min1 = 1.0e9, min2 = 1.0e9;
   bit seen1 = 1'b0, seen2 = 1'b0;

   always #2.5 ref_clk  = ~ref_clk;
   always #7   src44_x1 = ~src44_x1;
   always #3.5 src44_x2 = ~src44_x2;
   always #6   src48_x1 = ~src48_x1;
   always #3   src48_x2 = ~src48_x2;

   aclk_switch #(.QUIET_CYC(QC), .LOCK_CYC(LC), .SYNC_STAGES(2)) uut (
      .ref_clk(ref_clk), .rst_n(rst_n), .chip_en(chip_en), .fs_sel(fs_sel),
      .src44_x1(src44_x1), .src44_x2(src44_x2), .src48_x1(src48_x1), .src48_x2(src48_x2),
      .aud_out1(aud_out1), .aud_out2(aud_out2), .aud_valid(aud_valid));

   // R8 pulse-width monitor
   always @(posedge aud_out1) begin r1 = $realtime; seen1 = 1'b1; end
   always @(negedge aud_out1) if (seen1 && ($realtime - r1) < min1) min1 = $realtime - r1;
   always @(posedge aud_out2) begin r2 = $realtime; seen2 = 1'b1; end
   always @(negedge aud_out2) if (seen2 && ($realtime - r2) < min2) min2 = $realtime - r2;

   function automatic logic exp_out(input logic sel, input bit second);
      if (sel) return second ? src48_x2 : src48_x1;
      return second ? src44_x2 : src44_x1;
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      ncmp++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic cmp_outs(input string tag, input logic sel, input int n);
      repeat (n) begin
         @(negedge ref_clk);
         #0.3;
         chk(tag, aud_out1, exp_out(sel, 1'b0));
         chk(tag, aud_out2, exp_out(sel, 1'b1));
      end
   endtask

   task automatic quiet_lows(input string tag, input int n);
      repeat (n) begin
         step(1);
         chk(tag, aud_out1, 1'b0);
         chk(tag, aud_out2, 1'b0);
      end
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(1234);
      step(4);
      chk("R1 reset out1", aud_out1, 1'b0);
      chk("R1 reset out2", aud_out2, 1'b0);
      chk("R1 reset valid", aud_valid, 1'b0);
      rst_n = 1'b1;
      step(6);
      chk("R1 disabled valid", aud_valid, 1'b0);
      chk("R1 disabled out1", aud_out1, 1'b0);

      // R3 lock wait
      chip_en = 1'b1;
      step(LC + 2);
      chk("R3 lock still low", aud_valid, 1'b0);
      chk("R3 out1 low in lock", aud_out1, 1'b0);
      step(1);
      chk("R3 valid after lock", aud_valid, 1'b1);
      step(10);
      cmp_outs("R2 44.1 family", 1'b0, 16);

      // R4 / R5 select change
      fs_sel = 1'b1;
      step(2);
      chk("R4 valid through edge 2", aud_valid, 1'b1);
      step(1);
      chk("R4 valid drops edge 3", aud_valid, 1'b0);
      step(6);
      quiet_lows("R5 quiet outputs", QC - 7);
      chk("R4 still quiet", aud_valid, 1'b0);
      step(1);
      chk("R4 valid back", aud_valid, 1'b1);
      step(10);
      cmp_outs("R2 48 family", 1'b1, 16);

      // R6 restart of the quiet window
      fs_sel = 1'b0;
      step(3);
      chk("R6 first drop", aud_valid, 1'b0);
      step(7);
      fs_sel = 1'b1;
      step(QC + 2);
      chk("R6 window extended", aud_valid, 1'b0);
      step(1);
      chk("R6 release after restart", aud_valid, 1'b1);
      step(10);
      cmp_outs("R6 family after restart", 1'b1, 16);

      // random toggles, gaps down to one cycle
      for (int i = 0; i < 60; i++) begin
         if ($urandom % 2) fs_sel = ~fs_sel;
         step($urandom_range(1, QC + 8));
      end
      step(QC + 20);
      chk("R2 random valid", aud_valid, 1'b1);
      cmp_outs("R2 random family", fs_sel, 32);

      // R7 disable
      chip_en = 1'b0;
      step(3);
      chk("R7 valid off", aud_valid, 1'b0);
      step(12);
      chk("R7 out1 off", aud_out1, 1'b0);
      chk("R7 out2 off", aud_out2, 1'b0);
      fs_sel = ~fs_sel;
      quiet_lows("R7 select ignored while off", 20);
      chk("R7 valid stays off", aud_valid, 1'b0);

      // re-enable with the new selection
      chip_en = 1'b1;
      step(LC + 3);
      chk("R3 re-enable valid", aud_valid, 1'b1);
      step(10);
      cmp_outs("R2 after re-enable", fs_sel, 16);

      // R8 / R9 pulse widths (no runt, no overlap of families)
      chk("R8 out1 min width", (min1 >= 5.99) ? 1'b1 : 1'b0, 1'b1);
      chk("R8 out2 min width", (min2 >= 2.99) ? 1'b1 : 1'b0, 1'b1);
      chk("R9 monitor saw pulses", (seen1 && seen2) ? 1'b1 : 1'b0, 1'b1);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         ncmp++;
         nerr++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
         $finish;
      end
   end
endmodule